// File: doc/BRIEF.md
# Tap Delay Channel Sequencer

This block sequences one channel of a sampled transport-delay line. Each sample pulse starts one pass through a four-stage one-hot control register. The pass first takes one converted input word from a shared converter. It then writes that word into a circular word store at a moving write pointer and advances the pointer. Next it fetches the stored word two positions ahead of the write into a channel holding register. Last, it hands that word to the channel output register when the shared output selector next comes round to the channel. With a store of N words, each output word is the sample taken N-2 pulses earlier. The delay in time is therefore set by the pulse rate and not by the logic.

The converted word arrives on a valid/ready handshake. The converter raises `conv_valid` with `conv_data` and must hold both unchanged until a cycle in which `conv_ready` is also high. The word is taken on that clock edge. `conv_ready` is high only while the channel waits in its first stage and the shared selector points at it, so the sequencer applies back-pressure at all other times. Control pins (`sample_pulse`, `chan_sel`, `word_tick`) and status pins (`stage`, `overrun`, `out_strobe`) are plain levels sampled or driven on the rising clock edge. Reset is active low and asynchronous to no one: it is sampled on the clock.

Top module: `tap_delay_seq`

## Requirements
- R1: While `rst_n` is low, `stage` is 4'b0000, and `out_data`, `out_strobe`, `overrun` and `conv_ready` are all zero; every store word reads as zero after reset.
- R2: `stage` encodes idle as 4'b0000, capture-wait as 4'b0001, buffer-hold as 4'b0010, write/fetch as 4'b0100 and output-wait as 4'b1000; a `sample_pulse` seen in idle gives 4'b0001 one cycle later.
- R3: `conv_ready` is high exactly when `stage` is 4'b0001 and `chan_sel` is high; a cycle with `conv_valid` and `conv_ready` both high captures `conv_data` and moves `stage` to 4'b0010, otherwise `stage` stays 4'b0001.
- R4: In 4'b0010 the stage holds until a cycle with `word_tick` high, after which it is 4'b0100.
- R5: The first cycle in 4'b0100 writes the held word at the write pointer and advances the pointer by one, wrapping from N-1 to 0; `word_tick` in that cycle is not counted, and the second counted `word_tick` afterwards loads the word two positions past the written one into the holding register and moves `stage` to 4'b1000.
- R6: In 4'b1000 a cycle with `chan_sel` and `word_tick` both high copies the holding register to `out_data`, raises `out_strobe` for exactly the next cycle and returns `stage` to 4'b0000; otherwise the stage holds with `out_strobe` low.
- R7: Counting accepted pulses from 0 after reset, the word output for pulse k is the word captured for pulse k+2-N, or zero when k+2 < N.
- R8: A `sample_pulse` seen while `stage` is not 4'b0000 raises `overrun` for the next cycle and leaves the stage sequence and the stored data unaffected.
- R9: `out_data` changes only in a cycle where `out_strobe` is high.
- R10: `stage` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| sample_pulse | input | 1 | Starts one pass when idle |
| conv_valid | input | 1 | Converter word is offered |
| conv_ready | output | 1 | Channel accepts the converter word |
| conv_data | input | WIDTH | Converted sample word |
| chan_sel | input | 1 | Shared selector points at this channel |
| word_tick | input | 1 | One-cycle word-time marker |
| out_data | output | WIDTH | Channel output register |
| out_strobe | output | 1 | High for the cycle after `out_data` is loaded |
| overrun | output | 1 | Pulse arrived while busy; it was dropped |
| stage | output | 4 | One-hot control stage, zero when idle |

## Verification
The bench builds the block with an eight-word store and twelve-bit words. With this short ring, 48 passes wrap the write pointer six times. The first six outputs must still show the zero-filled ring, and later outputs must match the word captured six pulses earlier, so any slip in the write or fetch position changes the data seen at the output. The selector and word-time markers are driven in three ways: random, held high on every cycle (the shortest pass), and sparse (long back-pressure in the capture stage). Stray pulses are injected in every non-idle stage to exercise the dropped-pulse path.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef logic [3:0] stage_t;

  localparam stage_t ST_IDLE = 4'b0000;
  localparam stage_t ST_CAP  = 4'b0001;
  localparam stage_t ST_HOLD = 4'b0010;
  localparam stage_t ST_WRF  = 4'b0100;
  localparam stage_t ST_OUT  = 4'b1000;

  // distance from the written word to the fetched word
  localparam int LOOKAHEAD = 2;
  // word times counted between the store write and the fetch
  localparam int GAP_TICKS = 2;
endpackage

// File: rtl/tds_seq.sv
module tds_seq
  import tds_pkg::*;
#(
  parameter int GAP = GAP_TICKS
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sample_pulse,
  input  logic   conv_valid,
  input  logic   chan_sel,
  input  logic   word_tick,
  output stage_t stage,
  output logic   conv_ready,
  output logic   cap_en,
  output logic   wr_en,
  output logic   fetch_en,
  output logic   out_en,
  output logic   overrun
);
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

  stage_t        stage_q;
  logic          wrote_q;
  logic [CW-1:0] tick_cnt_q;
  logic          gap_done;

  assign stage = stage_q;

  always_comb begin
    conv_ready = (stage_q == ST_CAP) && chan_sel;
    cap_en     = conv_ready && conv_valid;
    wr_en      = (stage_q == ST_WRF) && !wrote_q;
    gap_done   = word_tick && (tick_cnt_q == CW'(GAP - 1));
    fetch_en   = (stage_q == ST_WRF) && wrote_q && gap_done;
    out_en     = (stage_q == ST_OUT) && chan_sel && word_tick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q    <= ST_IDLE;
      wrote_q    <= 1'b0;
      tick_cnt_q <= '0;
      overrun    <= 1'b0;
    end else begin
      overrun <= sample_pulse && (stage_q != ST_IDLE);
      case (stage_q)
        ST_IDLE: if (sample_pulse) stage_q <= ST_CAP;
        ST_CAP:  if (cap_en) stage_q <= ST_HOLD;
        ST_HOLD: if (word_tick) stage_q <= ST_WRF;
        ST_WRF: begin
          if (wr_en) begin
            wrote_q <= 1'b1;
          end else if (fetch_en) begin
            stage_q    <= ST_OUT;
            wrote_q    <= 1'b0;
            tick_cnt_q <= '0;
          end else if (word_tick) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
          end
        end
        ST_OUT:  if (out_en) stage_q <= ST_IDLE;
        default: stage_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tds_store.sv
module tds_store #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 16,
  parameter int AHEAD = 2,
  localparam int FW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic [FW-1:0]    flag
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [FW:0]      sum;
  logic [FW-1:0]    rd_addr;

  // the pointer has already moved past the written word, so the
  // word AHEAD places past the write sits AHEAD-1 past the pointer
  always_comb begin
    sum = {1'b0, flag} + (FW+1)'(AHEAD - 1);
    if (sum >= (FW+1)'(DEPTH)) sum = sum - (FW+1)'(DEPTH);
    rd_addr = sum[FW-1:0];
    rd_data = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[flag] <= wr_data;
      flag      <= (flag == FW'(DEPTH - 1)) ? '0 : flag + 1'b1;
    end
  end
endmodule

// File: rtl/tds_datapath.sv
module tds_datapath #(
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] conv_data,
  input  logic             fetch_en,
  input  logic [WIDTH-1:0] rd_data,
  input  logic             out_en,
  output logic [WIDTH-1:0] hold_q,
  output logic [WIDTH-1:0] out_data,
  output logic             out_strobe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= '0;
      out_data   <= '0;
      out_strobe <= 1'b0;
    end else begin
      if (cap_en)        hold_q <= conv_data;
      else if (fetch_en) hold_q <= rd_data;
      if (out_en) out_data <= hold_q;
      out_strobe <= out_en;
    end
  end
endmodule

// File: rtl/tap_delay_seq.sv
module tap_delay_seq
  import tds_pkg::*;
#(
  parameter int WIDTH = 13,
  parameter int DEPTH = 16,
  localparam int FW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_pulse,
  input  logic             conv_valid,
  output logic             conv_ready,
  input  logic [WIDTH-1:0] conv_data,
  input  logic             chan_sel,
  input  logic             word_tick,
  output logic [WIDTH-1:0] out_data,
  output logic             out_strobe,
  output logic             overrun,
  output logic [3:0]       stage
);
  logic             cap_en;
  logic             wr_en;
  logic             fetch_en;
  logic             out_en;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] rd_data;
  logic [FW-1:0]    flag;

  tds_seq #(.GAP(GAP_TICKS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_pulse(sample_pulse),
    .conv_valid  (conv_valid),
    .chan_sel    (chan_sel),
    .word_tick   (word_tick),
    .stage       (stage),
    .conv_ready  (conv_ready),
    .cap_en      (cap_en),
    .wr_en       (wr_en),
    .fetch_en    (fetch_en),
    .out_en      (out_en),
    .overrun     (overrun)
  );

  tds_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AHEAD(LOOKAHEAD)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(hold_q),
    .rd_data(rd_data),
    .flag   (flag)
  );

  tds_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .conv_data (conv_data),
    .fetch_en  (fetch_en),
    .rd_data   (rd_data),
    .out_en    (out_en),
    .hold_q    (hold_q),
    .out_data  (out_data),
    .out_strobe(out_strobe)
  );
endmodule

// File: rtl/tds_chk.sv
module tds_chk #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 16,
  localparam int FW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_pulse,
  input logic             conv_valid,
  input logic             conv_ready,
  input logic             chan_sel,
  input logic             word_tick,
  input logic [WIDTH-1:0] out_data,
  input logic             out_strobe,
  input logic             overrun,
  input logic [3:0]       stage,
  input logic             wr_en,
  input logic [FW-1:0]    flag
);
  assert_stage_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 4'b0000 && sample_pulse) |=> (stage == 4'b0001));

  assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready |-> (stage == 4'b0001 && chan_sel));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready) |=> (stage == 4'b0010));

  assert_hold_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 4'b0010 && !word_tick) |=> (stage == 4'b0010));

  assert_flag_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flag == (($past(flag) == FW'(DEPTH - 1)) ? '0 : $past(flag) + 1'b1)));

  assert_out_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 4'b1000 && chan_sel && word_tick) |=> (out_strobe && stage == 4'b0000));

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pulse && stage != 4'b0000) |=> overrun);

  assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_strobe);
endmodule

bind tap_delay_seq tds_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_pulse(sample_pulse),
  .conv_valid  (conv_valid),
  .conv_ready  (conv_ready),
  .chan_sel    (chan_sel),
  .word_tick   (word_tick),
  .out_data    (out_data),
  .out_strobe  (out_strobe),
  .overrun     (overrun),
  .stage       (stage),
  .wr_en       (wr_en),
  .flag        (flag)
);

// File: tb/tap_delay_seq_test.sv
`timescale 1ns/1ps
module tap_delay_seq_test;
  localparam int W = 12;
  localparam int N = 8;
  localparam int PASSES = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sample_pulse = 1'b0;
  logic         conv_valid = 1'b0;
  logic         conv_ready;
  logic [W-1:0] conv_data = '0;
  logic         chan_sel = 1'b0;
  logic         word_tick = 1'b0;
  logic [W-1:0] out_data;
  logic         out_strobe;
  logic         overrun;
  logic [3:0]   stage;

  int checks = 0;
  int errors = 0;
  int seed_v;

  tap_delay_seq #(.WIDTH(W), .DEPTH(N)) uut (
    .clk(clk), .rst_n(rst_n), .sample_pulse(sample_pulse),
    .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_data(conv_data),
    .chan_sel(chan_sel), .word_tick(word_tick), .out_data(out_data),
    .out_strobe(out_strobe), .overrun(overrun), .stage(stage));

  always #4 clk = ~clk;

  logic [W-1:0] samp [64];
  int k_issue = 0, k_done = 0, mode = 0;
  logic [3:0]   prev_st = 4'b0000;
  logic         prev_pulse = 0, prev_tick = 0, prev_sel = 0, prev_hs = 0;
  logic         prev_cfirst = 0, valid_hold = 0;
  logic [W-1:0] prev_out = '0;
  int c_ticks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_word(input int k);
    if (k + 2 < N) return 0;
    return int'(samp[k + 2 - N]);
  endfunction

  task automatic step();
    logic [3:0] st;
    logic [3:0] exp_st;
    logic       hs;
    @(negedge clk);
    st = stage;
    chk($countones(st) <= 1, "R10", "stage one-hot", int'(st), 0);
    if (!out_strobe)
      chk(out_data == prev_out, "R9", "out_data held", int'(out_data), int'(prev_out));
    if (prev_pulse && prev_st == 4'b0000)
      chk(st == 4'b0001, "R2", "start stage", int'(st), 1);
    if (prev_pulse && prev_st != 4'b0000)
      chk(overrun == 1'b1, "R8", "overrun flag", int'(overrun), 1);
    if (prev_st == 4'b0001)
      chk(st == (prev_hs ? 4'b0010 : 4'b0001), "R3", "capture step",
          int'(st), prev_hs ? 2 : 1);
    if (prev_st == 4'b0010)
      chk(st == (prev_tick ? 4'b0100 : 4'b0010), "R4", "hold step",
          int'(st), prev_tick ? 4 : 2);
    if (prev_st == 4'b0100) begin
      if (!prev_cfirst && prev_tick) c_ticks++;
      exp_st = (c_ticks == 2) ? 4'b1000 : 4'b0100;
      chk(st == exp_st, "R5", "write/fetch step", int'(st), int'(exp_st));
      if (c_ticks == 2) c_ticks = 0;
    end
    if (prev_st == 4'b1000) begin
      if (prev_sel && prev_tick) begin
        chk(out_strobe && st == 4'b0000, "R6", "output load", int'({out_strobe, st}), 16);
        chk(out_data == W'(exp_word(k_done)), "R7", "delayed word",
            int'(out_data), exp_word(k_done));
        k_done++;
      end else begin
        chk(!out_strobe && st == 4'b1000, "R6", "output wait", int'({out_strobe, st}), 8);
      end
    end
    prev_cfirst = (st == 4'b0100) && (prev_st != 4'b0100);
    prev_out = out_data;
    // drive next inputs
    case (mode)
      1: begin chan_sel = 1'b1; word_tick = 1'b1; end
      2: begin chan_sel = ($urandom % 6) == 0; word_tick = ($urandom % 5) == 0; end
      default: begin chan_sel = ($urandom % 2) == 0; word_tick = ($urandom % 3) == 0; end
    endcase
    if (st == 4'b0000) begin
      sample_pulse = (k_issue < PASSES) && (mode == 1 || ($urandom % 3) == 0);
      if (sample_pulse) begin
        samp[k_issue] = W'($urandom);
        conv_data = samp[k_issue];
        k_issue++;
      end
    end else begin
      sample_pulse = ($urandom % 11) == 0;
    end
    conv_valid = (st == 4'b0001) && (valid_hold || mode == 1 || ($urandom % 2) == 0);
    #1;
    chk(conv_ready == (st == 4'b0001 && chan_sel), "R3", "ready gating",
        int'(conv_ready), int'(st == 4'b0001 && chan_sel));
    hs = conv_valid && conv_ready;
    valid_hold = conv_valid && !hs;
    prev_hs = hs;
    prev_st = st;
    prev_pulse = sample_pulse;
    prev_tick = word_tick;
    prev_sel = chan_sel;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after %0d passes expected=%0d", k_done, PASSES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_v = $urandom(20240611);
    chan_sel = 1'b1;
    sample_pulse = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stage == 4'b0000, "R1", "reset stage", int'(stage), 0);
    chk(out_data == '0, "R1", "reset out_data", int'(out_data), 0);
    chk(!out_strobe && !overrun, "R1", "reset strobes", int'({out_strobe, overrun}), 0);
    chk(!conv_ready, "R1", "reset ready", int'(conv_ready), 0);
    sample_pulse = 1'b0;
    chan_sel = 1'b0;
    rst_n = 1'b1;
    mode = 0;
    while (k_done < 16) step();
    mode = 1;
    while (k_done < 24) step();
    mode = 2;
    while (k_done < 32) step();
    mode = 0;
    while (k_done < PASSES) step();
    repeat (3) step();
    chk(k_done == PASSES, "R7", "pass count", k_done, PASSES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule